// File: doc/BRIEF.md
# Clock-Generator Configuration Serial Slave

This block is the configuration port of a clock generator. It is a standard-mode I2C slave that holds six 8-bit configuration bytes. It drives them out in parallel to the clock-enable and frequency-select logic. SCL and SDA are oversampled by a fast system clock. The slave pulls SDA low through an open-drain output enable, and it never holds SCL.

Only two kinds of transfer are understood.

A block write begins with the write address byte D2h. The two bytes that follow are a command code and a byte count. Both are acknowledged and thrown away. After them, data bytes fill the configuration bytes in order from byte 0.

A block read begins with the read address byte D3h. The slave answers with a byte count and then sends bytes 0 to 5 in order.

Some bit positions of the read-back carry the frequency-select strap levels. These levels are latched just after reset, and they replace the stored bits at those positions.

Top module: `ckgen_cfg_slave`

## Requirements
- R1: The slave acknowledges the address bytes D2h (write) and D3h (read). Any other address byte is not acknowledged, and the slave ignores every later byte until the next START.
- R2: In a write, the first two bytes after the address are acknowledged and change no configuration byte.
- R3: Write data bytes are acknowledged and stored in configuration bytes 0, 1, 2 and so on, restarting at byte 0 in every write. A STOP after any complete byte keeps all bytes already stored and leaves the rest unchanged.
- R4: Data bytes after the sixth in one write are acknowledged and discarded.
- R5: A read sends 06h first, then bytes 0 to 5, most significant bit first. If the master keeps acknowledging, every further byte reads as FFh (SDA released).
- R6: Strap input bits are captured on the first clock after reset and held from then on. In read-back, byte 1 bit 7 = strap[3], bit 6 = strap[0], bit 5 = strap[2]. In read-back, byte 4 bit 4 = strap[4], bit 2 = strap[1]. The parallel output always shows the stored bits.
- R7: A master NACK after a read byte ends the read. SDA stays released until the next START.
- R8: After reset the parallel output is FF_EB_FF_FF_1F_00h, with byte 5 at the top and byte 0 at the bottom.
- R9: Configuration byte k appears on cfg_o[8k+7:8k]. It updates exactly 3 clk cycles after SCL falls at the end of that byte's eighth bit, and at no other time. SDA drive changes only in response to an SCL fall, a START or a STOP.
- R10: A START, including a repeated START inside a transfer, returns the slave to address reception. A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 5 | Frequency-select strap levels, captured after reset |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_o | output | 48 | Six stored configuration bytes, byte k at bits 8k+7:8k |

## Verification
An SCL or SDA change is seen by the sequencer 2 clk cycles after the line moves. It acts on the third edge. Both the parallel output and the SDA drive therefore change 3 cycles after the SCL fall that causes them.

The bench drives the bus at negative clock edges. It holds each bus level for 20 clocks, and it samples SDA in the middle of each high phase, well after the slave's drive has settled. A behavioural model queues every committed write byte, applies it on the third rising edge after the bench lowers SCL, and compares the parallel output with the model one nanosecond after every rising edge.

// File: rtl/ckgen_cfg_pkg.sv
package ckgen_cfg_pkg;
  localparam int CFG_BYTES = 6;
  localparam int BYTE_W    = 8;
  localparam int STRAP_W   = 5;
  localparam int CFG_W     = CFG_BYTES * BYTE_W;
  localparam int IDX_W     = $clog2(CFG_BYTES + 2);

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    RK_ADDR, RK_CMD, RK_CNT, RK_DATA
  } rx_kind_e;

  function automatic logic [BYTE_W-1:0] reset_byte(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h1F;
      4:       return 8'hEB;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] strap_overlay(
    input int                  idx,
    input logic [BYTE_W-1:0]   stored,
    input logic [STRAP_W-1:0]  st
  );
    logic [BYTE_W-1:0] r;
    r = stored;
    if (idx == 1) begin
      r[7] = st[3];
      r[6] = st[0];
      r[5] = st[2];
    end
    if (idx == 4) begin
      r[4] = st[4];
      r[2] = st[1];
    end
    return r;
  endfunction
endpackage

// File: rtl/ckgen_bus_sync.sv
module ckgen_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign ev_rise  = scl_s & ~scl_prev;
  assign ev_fall  = ~scl_s & scl_prev;
  assign ev_start = scl_s & scl_prev & sda_prev & ~sda_s;
  assign ev_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/ckgen_reg_bank.sv
module ckgen_reg_bank
  import ckgen_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [STRAP_W-1:0] strap_q,
  output logic               strap_vld
);
  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= reset_byte(g);
      else if (wr_en && wr_idx == IDX_W'(g))    q <= wr_data;
    end
    assign cfg_o[g*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q   <= '0;
      strap_vld <= 1'b0;
    end else if (!strap_vld) begin
      strap_q   <= strap_i;
      strap_vld <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < CFG_BYTES; i++) begin
      if (rd_idx == IDX_W'(i))
        rd_data = strap_overlay(i, cfg_o[i*BYTE_W +: BYTE_W], strap_q);
    end
  end
endmodule

// File: rtl/ckgen_xfer_fsm.sv
module ckgen_xfer_fsm
  import ckgen_cfg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR7  = 7'h69,
  parameter logic [BYTE_W-1:0] COUNT_BYTE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              in_addr
);
  localparam logic [IDX_W-1:0] WR_LIMIT = IDX_W'(CFG_BYTES);
  localparam logic [IDX_W-1:0] RD_LIMIT = IDX_W'(CFG_BYTES + 1);

  phase_e            phase;
  rx_kind_e          kind;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] sr;
  logic              rd_mode;
  logic [IDX_W-1:0]  wr_ptr, rd_pos;
  logic [BYTE_W-1:0] tx_byte;
  logic              byte_end;

  assign tx_byte  = (rd_pos == '0) ? COUNT_BYTE : rd_data;
  assign rd_idx   = IDX_W'(rd_pos - 1'b1);
  assign byte_end = (phase == PH_RX) && ev_fall && (bit_cnt == 4'd8);
  assign wr_en    = byte_end && (kind == RK_DATA) && (wr_ptr < WR_LIMIT)
                    && !ev_start && !ev_stop;
  assign wr_idx   = wr_ptr;
  assign wr_data  = sr;
  assign in_addr  = (phase == PH_RX) && (kind == RK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind    <= RK_ADDR;
      bit_cnt <= '0;
      sr      <= '0;
      rd_mode <= 1'b0;
      wr_ptr  <= '0;
      rd_pos  <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_start) begin
      phase   <= PH_RX;
      kind    <= RK_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      phase   <= PH_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (ev_rise && bit_cnt < 4'd8) begin
            sr      <= {sr[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            case (kind)
              RK_ADDR: begin
                if (sr[7:1] == DEV_ADDR7) begin
                  sda_oe  <= 1'b1;
                  phase   <= PH_RX_ACK;
                  rd_mode <= sr[0];
                  kind    <= RK_CMD;
                  wr_ptr  <= '0;
                  rd_pos  <= '0;
                end else begin
                  phase   <= PH_IDLE;
                end
              end
              RK_CMD: begin
                sda_oe <= 1'b1;
                phase  <= PH_RX_ACK;
                kind   <= RK_CNT;
              end
              RK_CNT: begin
                sda_oe <= 1'b1;
                phase  <= PH_RX_ACK;
                kind   <= RK_DATA;
              end
              default: begin
                sda_oe <= 1'b1;
                phase  <= PH_RX_ACK;
                if (wr_ptr < WR_LIMIT) wr_ptr <= wr_ptr + 1'b1;
              end
            endcase
          end
        end
        PH_RX_ACK: begin
          if (ev_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              phase  <= PH_TX;
              sr     <= tx_byte;
              sda_oe <= ~tx_byte[7];
            end else begin
              phase  <= PH_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        PH_TX: begin
          if (ev_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_ACK;
              if (rd_pos != RD_LIMIT) rd_pos <= rd_pos + 1'b1;
            end else begin
              sr      <= {sr[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~sr[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        PH_TX_ACK: begin
          if (ev_rise && sda_s) begin
            phase <= PH_IDLE;
          end else if (ev_fall) begin
            phase   <= PH_TX;
            sr      <= tx_byte;
            sda_oe  <= ~tx_byte[7];
            bit_cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ckgen_cfg_slave.sv
module ckgen_cfg_slave
  import ckgen_cfg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR7   = 7'h69,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] COUNT_BYTE  = 8'h06
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [CFG_W-1:0]   cfg_o
);
  logic              sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  logic              wr_en, in_addr, strap_vld;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [STRAP_W-1:0] strap_q;

  ckgen_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  ckgen_xfer_fsm #(.DEV_ADDR7(DEV_ADDR7), .COUNT_BYTE(COUNT_BYTE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .in_addr(in_addr)
  );

  ckgen_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .cfg_o(cfg_o), .strap_q(strap_q), .strap_vld(strap_vld)
  );
endmodule

// File: rtl/ckgen_cfg_checker.sv
module ckgen_cfg_checker
  import ckgen_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ev_fall,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               sda_oe,
  input logic [CFG_W-1:0]   cfg,
  input logic               in_addr,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [STRAP_W-1:0] strap_q,
  input logic               strap_vld
);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> in_addr);
  // R9
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fall || ev_start || ev_stop) |=> $stable(sda_oe));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fall |=> $stable(cfg));
  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < CFG_BYTES));
  // R6
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_vld |=> (strap_vld && $stable(strap_q)));
endmodule

bind ckgen_cfg_slave ckgen_cfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fall(ev_fall), .ev_start(ev_start),
  .ev_stop(ev_stop), .sda_oe(sda_oe_o), .cfg(cfg_o), .in_addr(in_addr),
  .wr_en(wr_en), .wr_idx(wr_idx), .strap_q(strap_q), .strap_vld(strap_vld)
);

// File: tb/ckgen_cfg_slave_bench.sv
`timescale 1ns/1ps
module ckgen_cfg_slave_bench;
  localparam int HALF = 20;

  logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, sda_drv = 1'b1;
  logic [4:0]  strap = 5'b10110;
  logic        sda_oe;
  logic [47:0] cfg;
  wire         sda_line = sda_drv & ~sda_oe;

  always #2.5 clk = ~clk;

  ckgen_cfg_slave u_ckgen_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] model [6];
  logic [4:0] strap_lat = 5'b10110;
  int pend_cnt = 0, pend_idx = 0;
  logic [7:0] pend_val;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model_flat();
    logic [47:0] f;
    for (int k = 0; k < 6; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    logic [7:0] b;
    if (k > 5) return 8'hFF;
    b = model[k];
    if (k == 1) begin b[7] = strap_lat[3]; b[6] = strap_lat[0]; b[5] = strap_lat[2]; end
    if (k == 4) begin b[4] = strap_lat[4]; b[2] = strap_lat[1]; end
    return b;
  endfunction

  // per-clock reference comparison (R9): committed byte lands 3 rising edges
  // after the bench lowers SCL
  always @(posedge clk) begin
    #1;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) model[pend_idx] = pend_val;
    end
    if (rst_n && !finished)
      chk(cfg === model_flat(), "R9 cfg_o vs model", cfg, model_flat());
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic start_c();
    sda_drv = 1'b1; half();
    scl_drv = 1'b1; half();
    sda_drv = 1'b0; half();
    scl_drv = 1'b0; half();
  endtask

  task automatic stop_c();
    sda_drv = 1'b0; half();
    scl_drv = 1'b1; half();
    sda_drv = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, input int commit, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; half();
      scl_drv = 1'b1; half();
      scl_drv = 1'b0;
    end
    if (commit >= 0) begin
      pend_cnt = 3; pend_idx = commit; pend_val = b;
    end
    sda_drv = 1'b1; half();
    scl_drv = 1'b1;
    repeat (HALF/2) @(negedge clk);
    acked = !sda_line;
    repeat (HALF/2) @(negedge clk);
    scl_drv = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half();
      scl_drv = 1'b1;
      repeat (HALF/2) @(negedge clk);
      b[i] = sda_line;
      repeat (HALF/2) @(negedge clk);
      scl_drv = 1'b0;
    end
    sda_drv = !ack; half();
    scl_drv = 1'b1; half();
    scl_drv = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] q[$]);
    bit a;
    start_c();
    send_byte(8'hD2, -1, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'h5A, -1, a); chk(a, "R2 command code ack", a, 1);
    send_byte(8'h33, -1, a); chk(a, "R2 byte count ack", a, 1);
    for (int i = 0; i < q.size(); i++) begin
      send_byte(q[i], (i < 6) ? i : -1, a);
      if (i < 6) chk(a, "R3 data byte ack", a, 1);
      else       chk(a, "R4 extra byte ack", a, 1);
    end
    stop_c();
  endtask

  task automatic do_read(input int n, input bit last_ack, input bit with_stop);
    bit a; logic [7:0] b;
    start_c();
    send_byte(8'hD3, -1, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(b, 1'b1); chk(b == 8'h06, "R5 byte count", b, 8'h06);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, (k < n-1) ? 1'b1 : last_ack);
      if (k == 1 || k == 4) chk(b == exp_rd(k), "R6 strap read-back", b, exp_rd(k));
      else                  chk(b == exp_rd(k), "R5 read data", b, exp_rd(k));
    end
    if (with_stop) stop_c();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit a; logic [7:0] b;
    logic [7:0] q[$];
    model[0] = 8'h00; model[1] = 8'h1F; model[2] = 8'hFF;
    model[3] = 8'hFF; model[4] = 8'hEB; model[5] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    strap = 5'b01001;   // later strap changes must not reach read-back (R6)
    chk(cfg == 48'hFFEBFFFF1F00, "R8 reset value", cfg, 48'hFFEBFFFF1F00);

    q = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
    do_write(q); half();
    chk(cfg == 48'hF6E5D4C3B2A1, "R3 full write", cfg, 48'hF6E5D4C3B2A1);

    q = '{8'h12, 8'h34};
    do_write(q); half();
    chk(cfg == 48'hF6E5D4C33412, "R3 partial write", cfg, 48'hF6E5D4C33412);

    q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    do_write(q); half();
    chk(cfg == 48'h060504030201, "R4 overflow discarded", cfg, 48'h060504030201);

    start_c();
    send_byte(8'hA0, -1, a); chk(!a, "R1 foreign address not acked", a, 0);
    send_byte(8'hD2, -1, a); chk(!a, "R1 later byte ignored", a, 0);
    stop_c(); half();
    chk(cfg == 48'h060504030201, "R1 foreign transfer no effect", cfg, 48'h060504030201);

    do_read(6, 1'b0, 1'b1);
    chk(exp_rd(1) == 8'h22, "R6 byte1 overlay value", exp_rd(1), 8'h22);

    do_read(1, 1'b0, 1'b0);
    recv_byte(b, 1'b0); chk(b == 8'hFF, "R7 released after NACK", b, 8'hFF);
    chk(sda_oe == 1'b0, "R7 no drive after NACK", sda_oe, 0);
    stop_c(); half();
    chk(sda_oe == 1'b0, "R10 released after STOP", sda_oe, 0);

    start_c();
    send_byte(8'hD2, -1, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'h00, -1, a); chk(a, "R2 command code ack", a, 1);
    send_byte(8'h00, -1, a); chk(a, "R2 byte count ack", a, 1);
    send_byte(8'h11, 0, a);  chk(a, "R3 data byte ack", a, 1);
    do_read(7, 1'b0, 1'b1);  // repeated START, reads past byte 5 (R10, R5)
    half();
    chk(cfg == 48'h060504030211, "R10 repeated start write kept", cfg, 48'h060504030211);

    finish_run();
  end
endmodule